// File: doc/BRIEF.md
# Two-Stage Timeout Watchdog

This block is a system watchdog that resets the chip only after two consecutive expiries of its down-counter. The first expiry raises a sticky timeout flag. It also sends a one-cycle system-management interrupt request toward firmware, but only if two enable bits allow it. Firmware or the operating system can then react before the counter runs out again. Software starts the timer by clearing the halt bit and keeps it alive by writing the kick register. Clearing the timeout flag with a write-one between the two expiries prevents the reset.

A single-cycle `tick` input sets the time base; clock division is done elsewhere. Registers are reached through a flat synchronous write port and a combinational read port. The reset request is a single-cycle pulse, and a no-reboot control bit can suppress it. If the programmed period is T ticks, a hung system is reset between about T and 2T ticks after its last keepalive.

Top module: `tmo_watchdog`

## Requirements
- R1: After synchronous reset the timeout flag, both SMI enables and the no-reboot bit are 0, the halt bit is 1, the period and counter equal `DEF_PERIOD`, and `smi_req` and `sys_rst` are low.
- R2: While the halt bit (bit 11 of CTRL) is 0, each `tick` lowers the counter by one. While halt is 1, ticks leave the counter unchanged.
- R3: A `tick` that arrives with the counter at 0 and halt clear is an expiry. It reloads the counter from PERIOD and sets the timeout flag (bit 3 of STATUS).
- R4: An expiry produces a one-cycle `smi_req` pulse in the cycle after the expiring tick. This happens only when the local enable (bit 13 of SMIEN) and the global enable (bit 0 of SMIEN) are both 1.
- R5: An expiry that finds the timeout flag already set produces a one-cycle `sys_rst` pulse in the cycle after the tick, unless the no-reboot bit (bit 0 of CTRL) is 1. The flag is still set either way.
- R6: A STATUS write with bit 3 = 1 (value 0x08) clears the flag. Writes to other STATUS bits have no effect, and nothing else clears the flag.
- R7: Any write to KICK reloads the counter from PERIOD without touching the flag. A kick in the same cycle as an expiring tick wins, and no expiry occurs.
- R8: A PERIOD write does not change the running count. The new value takes effect at the next reload.
- R9: Register addresses are STATUS=0, CTRL=1, SMIEN=2, PERIOD=3 and KICK=4. Reading KICK returns the current counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Single-cycle count enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| smi_req | output | 1 | One-cycle interrupt request on qualified expiry |
| sys_rst | output | 1 | One-cycle reset request on second expiry |

## Verification
The assertions assume that PERIOD is never programmed to 0. A zero period would let expiries land on back-to-back ticks, and the single-cycle pulse properties would then not hold. They also assume that `tick` and the write strobe are clean synchronous levels. The stimulus keeps PERIOD at 3 or 5 and drives every input on the falling clock edge. Each write occupies one cycle with `tick` low, except for one deliberate cycle that places a kick on an expiring tick.

// File: rtl/wdt_pkg.sv
// Package: shared register addresses and bit positions for the two-stage
// watchdog. Assumes a flat register space with one address per register.
package wdt_pkg;
    localparam int ADDR_BITS = 3;

    localparam logic [ADDR_BITS-1:0] A_STATUS = 3'd0;
    localparam logic [ADDR_BITS-1:0] A_CTRL   = 3'd1;
    localparam logic [ADDR_BITS-1:0] A_SMIEN  = 3'd2;
    localparam logic [ADDR_BITS-1:0] A_PERIOD = 3'd3;
    localparam logic [ADDR_BITS-1:0] A_KICK   = 3'd4;

    localparam int B_FLAG     = 3;   // STATUS: timeout flag, write-one-to-clear
    localparam int B_HALT     = 11;  // CTRL: freeze counter
    localparam int B_NOREBOOT = 0;   // CTRL: suppress reset pulse
    localparam int B_SMI_LOC  = 13;  // SMIEN: watchdog-local interrupt enable
    localparam int B_SMI_GLB  = 0;   // SMIEN: global interrupt enable
endpackage

// File: rtl/wdt_regs.sv
// Module: control register file. Holds the halt/no-reboot control bits, the
// two interrupt enables and the period, and decodes the kick and flag-clear
// strobes. Assumes DATA_W covers bit 13 and CNT_W bits of period.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 3,
    parameter int CNT_W      = 16,
    parameter int DEF_PERIOD = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              halt,
    output logic              no_reboot,
    output logic              smi_loc,
    output logic              smi_glb,
    output logic [CNT_W-1:0]  period,
    output logic              kick,
    output logic              flag_clr
);
    localparam logic [CNT_W-1:0] PERIOD_RST = CNT_W'(DEF_PERIOD);

    logic wr_status, wr_ctrl, wr_smien, wr_period;
    logic unused_wdata;

    // Address decode of the write strobe.
    always_comb begin
        wr_status = reg_wr && (reg_addr == A_STATUS);
        wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
        wr_smien  = reg_wr && (reg_addr == A_SMIEN);
        wr_period = reg_wr && (reg_addr == A_PERIOD);
        kick      = reg_wr && (reg_addr == A_KICK);
        flag_clr  = wr_status && reg_wdata[B_FLAG];
    end

    assign unused_wdata = ^reg_wdata;

    // Control bits; halt defaults on so the timer is idle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt      <= 1'b1;
            no_reboot <= 1'b0;
        end else if (wr_ctrl) begin
            halt      <= reg_wdata[B_HALT];
            no_reboot <= reg_wdata[B_NOREBOOT];
        end
    end

    // Interrupt enables, both off after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smi_loc <= 1'b0;
            smi_glb <= 1'b0;
        end else if (wr_smien) begin
            smi_loc <= reg_wdata[B_SMI_LOC];
            smi_glb <= reg_wdata[B_SMI_GLB];
        end
    end

    // Period register, used only at the next reload.
    always_ff @(posedge clk) begin
        if (!rst_n)         period <= PERIOD_RST;
        else if (wr_period) period <= reg_wdata[CNT_W-1:0];
    end
endmodule

// File: rtl/wdt_counter.sv
// Module: down-counter with auto-reload. Flags an expiry when a tick finds
// the count at zero. A kick reloads and overrides a simultaneous expiry.
// Assumes tick is a one-cycle synchronous enable.
module wdt_counter #(
    parameter int CNT_W      = 16,
    parameter int DEF_PERIOD = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             halt,
    input  logic             kick,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(DEF_PERIOD);

    logic step;

    // A counting tick is one that is not frozen and not pre-empted by a kick.
    always_comb begin
        step   = tick && !halt && !kick;
        expire = step && (cnt == '0);
    end

    // Count update: kick reload, expiry reload, or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= CNT_RST;
        else if (kick)   cnt <= period;
        else if (expire) cnt <= period;
        else if (step)   cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/wdt_stage.sv
// Module: two-stage expiry tracker. Sets the sticky timeout flag and issues
// the interrupt and reset pulses. Assumes expire is a one-cycle strobe.
module wdt_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic flag_clr,
    input  logic smi_loc,
    input  logic smi_glb,
    input  logic no_reboot,
    output logic flag,
    output logic smi_req,
    output logic sys_rst
);
    // Sticky flag: set by expiry (which wins), cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (expire)   flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    // Registered pulses; reset uses the flag as it was before this expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smi_req <= 1'b0;
            sys_rst <= 1'b0;
        end else begin
            smi_req <= expire && smi_loc && smi_glb;
            sys_rst <= expire && flag && !no_reboot;
        end
    end
endmodule

// File: rtl/tmo_watchdog.sv
// Module: top of the two-stage timeout watchdog. Wires register file,
// counter and stage tracker, and muxes read data. Assumes DATA_W >= CNT_W
// and DATA_W >= 14.
module tmo_watchdog
    import wdt_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 3,
    parameter int CNT_W      = 16,
    parameter int DEF_PERIOD = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              smi_req,
    output logic              sys_rst
);
    localparam int PAD_W = DATA_W - CNT_W;

    logic             halt, no_reboot, smi_loc, smi_glb, kick, flag_clr;
    logic             expire, flag_q;
    logic [CNT_W-1:0] period, cnt_q;

    wdt_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .halt(halt), .no_reboot(no_reboot),
        .smi_loc(smi_loc), .smi_glb(smi_glb), .period(period),
        .kick(kick), .flag_clr(flag_clr)
    );

    wdt_counter #(
        .CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .halt(halt), .kick(kick),
        .period(period), .cnt(cnt_q), .expire(expire)
    );

    wdt_stage u_stage (
        .clk(clk), .rst_n(rst_n), .expire(expire), .flag_clr(flag_clr),
        .smi_loc(smi_loc), .smi_glb(smi_glb), .no_reboot(no_reboot),
        .flag(flag_q), .smi_req(smi_req), .sys_rst(sys_rst)
    );

    // Read-data mux by register address.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_STATUS: reg_rdata[B_FLAG] = flag_q;
            A_CTRL: begin
                reg_rdata[B_HALT]     = halt;
                reg_rdata[B_NOREBOOT] = no_reboot;
            end
            A_SMIEN: begin
                reg_rdata[B_SMI_LOC] = smi_loc;
                reg_rdata[B_SMI_GLB] = smi_glb;
            end
            A_PERIOD: reg_rdata = {{PAD_W{1'b0}}, period};
            A_KICK:   reg_rdata = {{PAD_W{1'b0}}, cnt_q};
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_checker.sv
// Module: property checker for the two-stage watchdog, bound to the top.
// Assumes the programmed period is never zero.
module wdt_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             halt,
    input logic             kick,
    input logic             flag_clr,
    input logic             flag_q,
    input logic             no_reboot,
    input logic             smi_loc,
    input logic             smi_glb,
    input logic [CNT_W-1:0] cnt_q,
    input logic             smi_req,
    input logic             sys_rst
);
    assert_halt_freezes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !kick) |=> $stable(cnt_q));

    assert_flag_from_expiry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(tick && !halt && !kick && (cnt_q == '0)));

    assert_smi_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |-> $past(smi_loc && smi_glb));

    assert_smi_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |=> !smi_req);

    assert_rst_second_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> ($past(flag_q) && !$past(no_reboot)));

    assert_rst_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |=> !sys_rst);

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);
endmodule

bind tmo_watchdog wdt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .halt(halt), .kick(kick),
    .flag_clr(flag_clr), .flag_q(flag_q), .no_reboot(no_reboot),
    .smi_loc(smi_loc), .smi_glb(smi_glb), .cnt_q(cnt_q),
    .smi_req(smi_req), .sys_rst(sys_rst)
);

// File: tb/tmo_watchdog_tb.sv
`timescale 1ns/1ps
module tmo_watchdog_tb;
    localparam int DW = 32;
    localparam int AW = 3;
    localparam int CW = 16;
    localparam int DEFP = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          smi_req, sys_rst;

    int n_chk = 0;
    int n_err = 0;
    int smi_seen, rst_seen;

    always #10 clk = ~clk;

    tmo_watchdog #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW), .DEF_PERIOD(DEFP)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .smi_req(smi_req), .sys_rst(sys_rst)
    );

    typedef struct packed {
        logic        wr;
        logic [2:0]  addr;
        logic [31:0] data;
        logic [7:0]  ticks;
        logic        e_flag;
        logic [3:0]  e_smi;
        logic [3:0]  e_rst;
        logic [15:0] e_cnt;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    // STATUS=0 CTRL=1 SMIEN=2 PERIOD=3 KICK=4
    localparam vec_t VEC [NV] = '{
        '{1'b1, 3'd3, 32'd3,      8'd5, 1'b0, 4'd0, 4'd0, 16'd16, 4'd2}, // R2 halted, R8
        '{1'b1, 3'd4, 32'd0,      8'd0, 1'b0, 4'd0, 4'd0, 16'd3,  4'd7}, // R7 kick
        '{1'b1, 3'd2, 32'h2001,   8'd0, 1'b0, 4'd0, 4'd0, 16'd3,  4'd9}, // R9 enables
        '{1'b1, 3'd1, 32'h0,      8'd3, 1'b0, 4'd0, 4'd0, 16'd0,  4'd2}, // R2 counting
        '{1'b0, 3'd0, 32'h0,      8'd1, 1'b1, 4'd1, 4'd0, 16'd3,  4'd3}, // R3/R4 first expiry
        '{1'b1, 3'd0, 32'h08,     8'd4, 1'b1, 4'd1, 4'd0, 16'd3,  4'd6}, // R6 clear stops reset
        '{1'b0, 3'd0, 32'h0,      8'd4, 1'b1, 4'd1, 4'd1, 16'd3,  4'd5}, // R5 second expiry
        '{1'b1, 3'd0, 32'h08,     8'd0, 1'b0, 4'd0, 4'd0, 16'd3,  4'd6}, // R6 clear
        '{1'b1, 3'd2, 32'h0001,   8'd4, 1'b1, 4'd0, 4'd0, 16'd3,  4'd4}, // R4 local off
        '{1'b1, 3'd2, 32'h2000,   8'd4, 1'b1, 4'd0, 4'd1, 16'd3,  4'd4}, // R4 global off, R5
        '{1'b1, 3'd1, 32'h0001,   8'd8, 1'b1, 4'd0, 4'd0, 16'd3,  4'd5}, // R5 no-reboot
        '{1'b1, 3'd1, 32'h0801,   8'd5, 1'b1, 4'd0, 4'd0, 16'd3,  4'd2}, // R2 halt
        '{1'b1, 3'd0, 32'h04,     8'd0, 1'b1, 4'd0, 4'd0, 16'd3,  4'd6}, // R6 other bit
        '{1'b1, 3'd1, 32'h0,      8'd2, 1'b1, 4'd0, 4'd0, 16'd1,  4'd2}, // R2
        '{1'b1, 3'd4, 32'h0,      8'd0, 1'b1, 4'd0, 4'd0, 16'd3,  4'd7}, // R7 flag kept
        '{1'b1, 3'd3, 32'd5,      8'd3, 1'b1, 4'd0, 4'd0, 16'd0,  4'd8}, // R8 no effect now
        '{1'b0, 3'd0, 32'h0,      8'd1, 1'b1, 4'd0, 4'd1, 16'd5,  4'd8}, // R8 new period, R5
        '{1'b1, 3'd0, 32'h08,     8'd6, 1'b1, 4'd0, 4'd0, 16'd5,  4'd3}  // R3 reload to 5
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic sample();
        if (smi_req) smi_seen++;
        if (sys_rst) rst_seen++;
    endtask

    // One clock: drive at falling edge, sample after the next falling edge.
    task automatic cyc(input logic t, input logic w, input logic [2:0] a, input logic [31:0] d);
        tick = t; reg_wr = w; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0; reg_wr = 1'b0;
        sample();
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic check_reset();
        logic [31:0] v;
        rd(3'd0, v); chk("R1 flag", v, 32'h0);
        rd(3'd1, v); chk("R1 ctrl", v, 32'h800);
        rd(3'd2, v); chk("R1 smien", v, 32'h0);
        rd(3'd3, v); chk("R1 period", v, 32'd16);
        rd(3'd4, v); chk("R9 count", v, 32'd16);
        chk("R1 smi_req", {31'b0, smi_req}, 32'h0);
        chk("R1 sys_rst", {31'b0, sys_rst}, 32'h0);
    endtask

    initial begin
        #(200000 * 20);
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] v;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset();

        for (int i = 0; i < NV; i++) begin
            smi_seen = 0; rst_seen = 0;
            if (VEC[i].wr) cyc(1'b0, 1'b1, VEC[i].addr, VEC[i].data);
            for (int k = 0; k < int'(VEC[i].ticks); k++) cyc(1'b1, 1'b0, 3'd0, 32'h0);
            rd(3'd0, v);
            chk($sformatf("R%0d vec%0d flag", VEC[i].req, i), {31'b0, v[3]}, {31'b0, VEC[i].e_flag});
            chk($sformatf("R%0d vec%0d smi", VEC[i].req, i), smi_seen, {28'b0, VEC[i].e_smi});
            chk($sformatf("R%0d vec%0d rst", VEC[i].req, i), rst_seen, {28'b0, VEC[i].e_rst});
            rd(3'd4, v);
            chk($sformatf("R%0d vec%0d cnt", VEC[i].req, i), v, {16'b0, VEC[i].e_cnt});
        end

        // R7: kick on the same cycle as an expiring tick wins.
        smi_seen = 0; rst_seen = 0;
        cyc(1'b0, 1'b1, 3'd0, 32'h08);
        for (int k = 0; k < 5; k++) cyc(1'b1, 1'b0, 3'd0, 32'h0);
        rd(3'd4, v); chk("R2 count at zero", v, 32'd0);
        cyc(1'b1, 1'b1, 3'd4, 32'h0);
        rd(3'd4, v); chk("R7 kick beats expiry cnt", v, 32'd5);
        rd(3'd0, v); chk("R7 kick beats expiry flag", v, 32'h0);
        chk("R7 kick beats expiry rst", rst_seen, 32'd0);

        // R1: synchronous reset mid-run restores defaults.
        cyc(1'b0, 1'b1, 3'd2, 32'h2001);
        for (int k = 0; k < 6; k++) cyc(1'b1, 1'b0, 3'd0, 32'h0);
        rd(3'd0, v); chk("R3 flag before reset", v, 32'h8);
        rst_n = 1'b0;
        cyc(1'b1, 1'b0, 3'd0, 32'h0);
        rst_n = 1'b1;
        check_reset();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule